// File: doc/BRIEF.md
# Shader Flow-Control Sequencer

This block produces the fetch address for a small vector shader core. Each cycle it takes the decoded flow-control fields of the instruction at the current address, together with two condition-code bits, and chooses the next address. It supports conditional and unconditional jumps, subroutine calls, two-way if/else regions and counted loops. All nested regions are tracked on one hardware return stack. Every stack frame has the same layout: end address, return address, repeat count, loop-counter increment and loop-back address.

Before any instruction runs, the sequencer compares the current address with the end address of the top frame. On a match it spends that cycle closing the region and does not execute the instruction. It adds the frame's increment to the 8-bit loop counter. It then either jumps back to the loop-back address, decrementing the repeat count, or jumps to the return address and pops the frame when the repeat count has reached zero. Instruction memory, uniform storage and arithmetic are outside the block; their values arrive as plain inputs.

Top module: `shader_flow_seq`

## Requirements
- R1: After reset, `fetchAddr` equals `entryPc`, `loopCtr` is 0, the stack is empty, and `halted` and `overflowErr` are both 0. A later reset clears both flags.
- R2: Opcode encoding is NOP=0, END=1, JMPC=2, JMPU=3, CALL=4, CALLU=5, CALLC=6, IFU=7, IFC=8, LOOP=9. NOP and any unlisted code advance the address by 1. END sets `halted`. While halted, the address and loop counter hold and all inputs are ignored.
- R3: The condition is formed from xHit = (`refX` == `cc0`) and yHit = (`refY` == `cc1`). `condMode` 0 selects xHit OR yHit, 1 selects AND, 2 selects xHit alone and 3 selects yHit alone. JMPC jumps to `dstOff` when this condition holds. JMPU jumps when `boolUni` is 1. Otherwise the address advances by 1.
- R4: CALL always pushes {end=dst+count, return=current+1, repeat 0, increment 0, loop-back=dst} and jumps to dst. CALLU pushes and jumps only when `boolUni` is 1. CALLC does so only when the condition holds. When the condition is false, both continue at current+1.
- R5: When the stack is non-empty and the address equals the top frame's end address, the instruction there is not executed in that cycle. A frame with repeat 0 returns to its return address and is popped.
- R6: IFU (test `boolUni`) and IFC (test the condition) push a frame. When the test is true the frame covers current+1 up to, but not including, dst, and execution continues at current+1. When it is false the frame covers dst to dst+count and execution jumps to dst. In both cases the frame returns to dst+count.
- R7: LOOP loads `loopCtr` from `intInit` and pushes {end=dst+1, return=dst+1, repeat=`intRepeat`, increment=`intIncr`, loop-back=current+1}. The body current+1..dst therefore runs `intRepeat`+1 times. Each end check adds the increment modulo 256 and, while the repeat count is non-zero, decrements it and jumps to the loop-back address.
- R8: Nested regions unwind in last-in, first-out order, and the stack never holds more than DEPTH frames.
- R9: A push attempted with DEPTH frames already stored is discarded. The loop counter is not loaded, execution continues at current+1, and `overflowErr` is set and stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| entryPc | input | ADDR_W | Address loaded at reset |
| opClass | input | 4 | Flow-control opcode of the current instruction |
| dstOff | input | ADDR_W | Destination offset field |
| instCount | input | ADDR_W | Instruction count field |
| boolUni | input | 1 | Selected boolean uniform value |
| intRepeat | input | CNT_W | Integer uniform field: repeat count |
| intInit | input | CNT_W | Integer uniform field: loop-counter start |
| intIncr | input | CNT_W | Integer uniform field: per-pass increment |
| refX | input | 1 | Reference bit compared with cc0 |
| refY | input | 1 | Reference bit compared with cc1 |
| condMode | input | 2 | Condition combine mode |
| cc0 | input | 1 | Condition code 0 |
| cc1 | input | 1 | Condition code 1 |
| fetchAddr | output | ADDR_W | Address of the instruction to fetch |
| loopCtr | output | CNT_W | Loop counter register |
| halted | output | 1 | END has executed |
| overflowErr | output | 1 | Sticky stack overflow flag |

## Verification
The hardest situation to reach is a stack overflow, because it requires DEPTH frames to be live at once. The stimulus gets there with a subroutine that calls its own entry address, so each cycle pushes one more frame until the next push finds the stack full. The other difficult case is an address that is both the end of a region and an instruction. For this, the bench places END or CALL instructions at end addresses, where executing them by mistake would change the trace. A loop whose counter starts near 255 exercises the wrap of the increment.

// File: rtl/flow_seq_pkg.sv
`timescale 1ns/1ps
package flow_seq_pkg;

  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_END   = 4'd1,
    OP_JMPC  = 4'd2,
    OP_JMPU  = 4'd3,
    OP_CALL  = 4'd4,
    OP_CALLU = 4'd5,
    OP_CALLC = 4'd6,
    OP_IFU   = 4'd7,
    OP_IFC   = 4'd8,
    OP_LOOP  = 4'd9
  } flowOp_e;

  typedef enum logic [2:0] {
    PC_HOLD = 3'd0,
    PC_NEXT = 3'd1,
    PC_DST  = 3'd2,
    PC_RET  = 3'd3,
    PC_BACK = 3'd4
  } pcSel_e;

  typedef enum logic [1:0] {
    PK_CALL = 2'd0,
    PK_THEN = 2'd1,
    PK_ELSE = 2'd2,
    PK_LOOP = 2'd3
  } pushKind_e;

  typedef struct packed {
    logic      doPush;
    logic      doPop;
    logic      decRep;
    logic      addIncr;
    logic      loadCtr;
    logic      setHalt;
    logic      setOvf;
    pushKind_e kind;
    pcSel_e    pcSel;
  } seqStrobe_t;

endpackage

// File: rtl/flow_seq_cond.sv
`timescale 1ns/1ps
module flow_seq_cond (
  input  logic       refX,
  input  logic       refY,
  input  logic [1:0] condMode,
  input  logic       cc0,
  input  logic       cc1,
  output logic       condOk
);
  logic xHit;
  logic yHit;

  assign xHit = (refX == cc0);
  assign yHit = (refY == cc1);

  always_comb begin
    case (condMode)
      2'd0:    condOk = xHit | yHit;
      2'd1:    condOk = xHit & yHit;
      2'd2:    condOk = xHit;
      default: condOk = yHit;
    endcase
  end
endmodule

// File: rtl/flow_seq_ctrl.sv
`timescale 1ns/1ps
module flow_seq_ctrl
  import flow_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       halted,
  input  logic       atEnd,
  input  logic       topRepZero,
  input  logic       stackFull,
  input  logic [3:0] opClass,
  input  logic       boolUni,
  input  logic       refX,
  input  logic       refY,
  input  logic [1:0] condMode,
  input  logic       cc0,
  input  logic       cc1,
  output seqStrobe_t strobe
);
  logic    condOk;
  logic    gate;
  flowOp_e op;

  assign op = flowOp_e'(opClass);

  flow_seq_cond u_cond (
    .refX(refX), .refY(refY), .condMode(condMode),
    .cc0(cc0), .cc1(cc1), .condOk(condOk)
  );

  always_comb begin
    strobe       = '0;
    strobe.pcSel = PC_HOLD;
    strobe.kind  = PK_CALL;
    gate         = 1'b0;
    if (!halted) begin
      if (atEnd) begin
        strobe.addIncr = 1'b1;
        if (topRepZero) begin
          strobe.doPop = 1'b1;
          strobe.pcSel = PC_RET;
        end else begin
          strobe.decRep = 1'b1;
          strobe.pcSel  = PC_BACK;
        end
      end else begin
        strobe.pcSel = PC_NEXT;
        case (op)
          OP_END: begin
            strobe.setHalt = 1'b1;
            strobe.pcSel   = PC_HOLD;
          end
          OP_JMPC: if (condOk)  strobe.pcSel = PC_DST;
          OP_JMPU: if (boolUni) strobe.pcSel = PC_DST;
          OP_CALL, OP_CALLU, OP_CALLC: begin
            gate = (op == OP_CALL) | ((op == OP_CALLU) & boolUni) | ((op == OP_CALLC) & condOk);
            if (gate) begin
              strobe.doPush = 1'b1;
              strobe.kind   = PK_CALL;
              strobe.pcSel  = PC_DST;
            end
          end
          OP_IFU, OP_IFC: begin
            gate          = (op == OP_IFU) ? boolUni : condOk;
            strobe.doPush = 1'b1;
            strobe.kind   = gate ? PK_THEN : PK_ELSE;
            strobe.pcSel  = gate ? PC_NEXT : PC_DST;
          end
          OP_LOOP: begin
            strobe.doPush  = 1'b1;
            strobe.kind    = PK_LOOP;
            strobe.loadCtr = 1'b1;
          end
          default: ;
        endcase
        if (strobe.doPush && stackFull) begin
          strobe.doPush  = 1'b0;
          strobe.loadCtr = 1'b0;
          strobe.setOvf  = 1'b1;
          strobe.pcSel   = PC_NEXT;
        end
      end
    end
  end

  // R8: a cycle never both pushes and pops
  p_push_pop_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.doPush, strobe.doPop}));
  // R9: nothing is pushed onto a full stack
  p_full_drop_r9: assert property (@(posedge clk) disable iff (!rstN)
    stackFull |-> !strobe.doPush);
  // R2: a halted sequencer issues no action
  p_halt_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> (strobe.pcSel == PC_HOLD && !strobe.doPush && !strobe.addIncr));
endmodule

// File: rtl/flow_seq_datapath.sv
`timescale 1ns/1ps
module flow_seq_datapath
  import flow_seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 8,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] entryPc,
  input  logic [ADDR_W-1:0] dstOff,
  input  logic [ADDR_W-1:0] instCount,
  input  logic [CNT_W-1:0]  intRepeat,
  input  logic [CNT_W-1:0]  intInit,
  input  logic [CNT_W-1:0]  intIncr,
  input  seqStrobe_t        strobe,
  output logic [ADDR_W-1:0] pc,
  output logic [CNT_W-1:0]  loopCtr,
  output logic              halted,
  output logic              ovfErr,
  output logic              atEnd,
  output logic              topRepZero,
  output logic              stackFull
);
  localparam int SP_W  = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  typedef struct packed {
    logic [ADDR_W-1:0] endA;
    logic [ADDR_W-1:0] retA;
    logic [ADDR_W-1:0] backA;
    logic [CNT_W-1:0]  rep;
    logic [CNT_W-1:0]  inc;
  } frame_t;

  frame_t            frames [DEPTH];
  frame_t            topF;
  frame_t            newF;
  logic [SP_W-1:0]   sp;
  logic [IDX_W-1:0]  topIdx;
  logic [IDX_W-1:0]  pushIdx;
  logic [ADDR_W-1:0] pcPlus1;
  logic [ADDR_W-1:0] dstEnd;
  logic [ADDR_W-1:0] nextPc;

  assign topIdx     = IDX_W'(sp - 1'b1);
  assign pushIdx    = IDX_W'(sp);
  assign topF       = frames[topIdx];
  assign pcPlus1    = pc + 1'b1;
  assign dstEnd     = dstOff + instCount;
  assign stackFull  = (sp == SP_W'(DEPTH));
  assign atEnd      = (sp != '0) && (pc == topF.endA);
  assign topRepZero = (topF.rep == '0);

  always_comb begin
    newF = '0;
    case (strobe.kind)
      PK_CALL: begin
        newF.endA = dstEnd;  newF.retA = pcPlus1; newF.backA = dstOff;
      end
      PK_THEN: begin
        newF.endA = dstOff;  newF.retA = dstEnd;  newF.backA = pcPlus1;
      end
      PK_ELSE: begin
        newF.endA = dstEnd;  newF.retA = dstEnd;  newF.backA = dstOff;
      end
      default: begin
        newF.endA  = dstOff + 1'b1;
        newF.retA  = dstOff + 1'b1;
        newF.backA = pcPlus1;
        newF.rep   = intRepeat;
        newF.inc   = intIncr;
      end
    endcase
  end

  always_comb begin
    case (strobe.pcSel)
      PC_NEXT: nextPc = pcPlus1;
      PC_DST:  nextPc = dstOff;
      PC_RET:  nextPc = topF.retA;
      PC_BACK: nextPc = topF.backA;
      default: nextPc = pc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc      <= entryPc;
      sp      <= '0;
      loopCtr <= '0;
      halted  <= 1'b0;
      ovfErr  <= 1'b0;
    end else begin
      pc <= nextPc;
      if (strobe.doPush)      sp <= sp + 1'b1;
      else if (strobe.doPop)  sp <= sp - 1'b1;
      if (strobe.loadCtr)      loopCtr <= intInit;
      else if (strobe.addIncr) loopCtr <= loopCtr + topF.inc;
      if (strobe.setHalt) halted <= 1'b1;
      if (strobe.setOvf)  ovfErr <= 1'b1;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_frame
    always_ff @(posedge clk) begin
      if (strobe.doPush && pushIdx == IDX_W'(i))
        frames[i] <= newF;
      else if (strobe.decRep && topIdx == IDX_W'(i))
        frames[i].rep <= frames[i].rep - 1'b1;
    end
  end

  // R5: closing a region lands on the popped frame's return address
  p_pop_returns_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doPop |=> (pc == $past(topF.retA)));
  // R7: a repeat pass jumps back and consumes one repeat
  p_loop_back_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.decRep |=> (pc == $past(topF.backA) && topF.rep == CNT_W'($past(topF.rep) - 1'b1)));
  // R2: once halted, address and flag hold
  p_halt_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> (halted && $stable(pc) && $stable(loopCtr)));
  // R9: overflow flag is sticky
  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    ovfErr |=> ovfErr);
  // R8: occupancy bounded by depth
  p_depth_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    sp <= SP_W'(DEPTH));
endmodule

// File: rtl/shader_flow_seq.sv
`timescale 1ns/1ps
module shader_flow_seq
  import flow_seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 8,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] entryPc,
  input  logic [3:0]        opClass,
  input  logic [ADDR_W-1:0] dstOff,
  input  logic [ADDR_W-1:0] instCount,
  input  logic              boolUni,
  input  logic [CNT_W-1:0]  intRepeat,
  input  logic [CNT_W-1:0]  intInit,
  input  logic [CNT_W-1:0]  intIncr,
  input  logic              refX,
  input  logic              refY,
  input  logic [1:0]        condMode,
  input  logic              cc0,
  input  logic              cc1,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic [CNT_W-1:0]  loopCtr,
  output logic              halted,
  output logic              overflowErr
);
  seqStrobe_t strobe;
  logic       atEnd;
  logic       topRepZero;
  logic       stackFull;

  flow_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .halted(halted), .atEnd(atEnd),
    .topRepZero(topRepZero), .stackFull(stackFull), .opClass(opClass),
    .boolUni(boolUni), .refX(refX), .refY(refY), .condMode(condMode),
    .cc0(cc0), .cc1(cc1), .strobe(strobe)
  );

  flow_seq_datapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .entryPc(entryPc), .dstOff(dstOff),
    .instCount(instCount), .intRepeat(intRepeat), .intInit(intInit),
    .intIncr(intIncr), .strobe(strobe), .pc(fetchAddr), .loopCtr(loopCtr),
    .halted(halted), .ovfErr(overflowErr), .atEnd(atEnd),
    .topRepZero(topRepZero), .stackFull(stackFull)
  );
endmodule

// File: tb/shader_flow_seq_tb.sv
`timescale 1ns/1ps
module shader_flow_seq_tb;
  typedef struct packed {
    logic [3:0] op;
    logic [7:0] dst;
    logic [7:0] cnt;
    logic       bu;
    logic [7:0] rep;
    logic [7:0] ini;
    logic [7:0] inc;
    logic       rx;
    logic       ry;
    logic [1:0] mode;
  } instr_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] entryPc = '0;
  logic       cc0 = 1'b0;
  logic       cc1 = 1'b0;
  logic [7:0] fetchAddr;
  logic [7:0] loopCtr;
  logic       halted;
  logic       overflowErr;
  instr_t     prog [256];
  instr_t     cur;
  int         nChecks = 0;
  int         nFails = 0;

  always #10 clk = ~clk;

  assign cur = prog[fetchAddr];

  shader_flow_seq u_dut (
    .clk(clk), .rstN(rstN), .entryPc(entryPc), .opClass(cur.op),
    .dstOff(cur.dst), .instCount(cur.cnt), .boolUni(cur.bu),
    .intRepeat(cur.rep), .intInit(cur.ini), .intIncr(cur.inc),
    .refX(cur.rx), .refY(cur.ry), .condMode(cur.mode), .cc0(cc0), .cc1(cc1),
    .fetchAddr(fetchAddr), .loopCtr(loopCtr), .halted(halted),
    .overflowErr(overflowErr)
  );

  // row = {tag, halt, loopCtr, fetchAddr} after each edge of program A
  localparam logic [20:0] TRACE_A [30] = '{
    {4'd7,1'b0,8'd5,8'd1},   {4'd7,1'b0,8'd5,8'd2},   {4'd7,1'b0,8'd5,8'd3},
    {4'd7,1'b0,8'd8,8'd1},   {4'd7,1'b0,8'd8,8'd2},   {4'd7,1'b0,8'd8,8'd3},
    {4'd7,1'b0,8'd11,8'd1},  {4'd7,1'b0,8'd11,8'd2},  {4'd7,1'b0,8'd11,8'd3},
    {4'd7,1'b0,8'd14,8'd3},  {4'd4,1'b0,8'd14,8'd20}, {4'd4,1'b0,8'd14,8'd21},
    {4'd4,1'b0,8'd14,8'd22}, {4'd5,1'b0,8'd14,8'd4},  {4'd6,1'b0,8'd14,8'd7},
    {4'd6,1'b0,8'd14,8'd8},  {4'd5,1'b0,8'd14,8'd8},  {4'd6,1'b0,8'd14,8'd9},
    {4'd6,1'b0,8'd14,8'd10}, {4'd5,1'b0,8'd14,8'd11}, {4'd3,1'b0,8'd14,8'd13},
    {4'd4,1'b0,8'd14,8'd14}, {4'd4,1'b0,8'd14,8'd20}, {4'd4,1'b0,8'd14,8'd21},
    {4'd4,1'b0,8'd14,8'd22}, {4'd5,1'b0,8'd14,8'd15}, {4'd3,1'b0,8'd14,8'd16},
    {4'd3,1'b0,8'd14,8'd17}, {4'd2,1'b1,8'd14,8'd17}, {4'd2,1'b1,8'd14,8'd17}
  };

  function automatic string tagName(input logic [3:0] t);
    case (t)
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic putI(input int a, input logic [3:0] op, input int dst, input int cnt,
                      input logic bu, input int rep, input int ini, input int inc,
                      input logic rx, input logic ry, input logic [1:0] mode);
    prog[a] = {op, 8'(dst), 8'(cnt), bu, 8'(rep), 8'(ini), 8'(inc), rx, ry, mode};
  endtask

  task automatic clearProg();
    for (int i = 0; i < 256; i++) prog[i] = '0;
  endtask

  task automatic doReset(input int e);
    rstN = 1'b0;
    entryPc = 8'(e);
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    // Program A: loop, call, if/else, conditions, halt
    clearProg();
    putI(0,  4'd9, 2, 0, 0, 2, 5, 3, 0, 0, 2'd0);
    putI(3,  4'd4, 20, 2, 0, 0, 0, 0, 0, 0, 2'd0);
    putI(4,  4'd8, 7, 1, 0, 0, 0, 0, 1, 1, 2'd1);
    putI(8,  4'd7, 10, 1, 1, 0, 0, 0, 0, 0, 2'd0);
    putI(11, 4'd2, 13, 0, 0, 0, 0, 0, 1, 0, 2'd0);
    putI(12, 4'd1, 0, 0, 0, 0, 0, 0, 0, 0, 2'd0);
    putI(13, 4'd5, 20, 2, 0, 0, 0, 0, 0, 0, 2'd0);
    putI(14, 4'd6, 20, 2, 0, 0, 0, 0, 0, 0, 2'd3);
    putI(15, 4'd3, 40, 0, 0, 0, 0, 0, 0, 0, 2'd0);
    putI(16, 4'd2, 40, 0, 0, 0, 0, 0, 0, 0, 2'd2);
    putI(17, 4'd1, 0, 0, 0, 0, 0, 0, 0, 0, 2'd0);
    putI(22, 4'd1, 0, 0, 0, 0, 0, 0, 0, 0, 2'd0);
    cc0 = 1'b1;
    cc1 = 1'b0;
    doReset(0);
    chk("R1", "reset fetchAddr", int'(fetchAddr), 0);
    chk("R1", "reset loopCtr", int'(loopCtr), 0);
    chk("R1", "reset halted", int'(halted), 0);
    chk("R1", "reset overflowErr", int'(overflowErr), 0);
    for (int k = 0; k < 30; k++) begin
      step();
      chk(tagName(TRACE_A[k][20:17]), $sformatf("A edge %0d fetchAddr", k + 1),
          int'(fetchAddr), int'(TRACE_A[k][7:0]));
      chk(tagName(TRACE_A[k][20:17]), $sformatf("A edge %0d loopCtr", k + 1),
          int'(loopCtr), int'(TRACE_A[k][15:8]));
      chk(tagName(TRACE_A[k][20:17]), $sformatf("A edge %0d halted", k + 1),
          int'(halted), int'(TRACE_A[k][16]));
    end

    // Program B: loop counter wraps; END at end address skipped during checks (R7, R5)
    clearProg();
    putI(40, 4'd9, 41, 0, 0, 1, 250, 4, 0, 0, 2'd0);
    putI(42, 4'd1, 0, 0, 0, 0, 0, 0, 0, 0, 2'd0);
    doReset(40);
    step();
    chk("R7", "B load loopCtr", int'(loopCtr), 250);
    chk("R7", "B body addr", int'(fetchAddr), 41);
    step();
    step();
    chk("R5", "B end check not executed", int'(halted), 0);
    chk("R7", "B first pass loopCtr", int'(loopCtr), 254);
    chk("R7", "B loop back addr", int'(fetchAddr), 41);
    step();
    step();
    chk("R7", "B wrapped loopCtr", int'(loopCtr), 2);
    chk("R7", "B exit addr", int'(fetchAddr), 42);
    chk("R5", "B still running after pop", int'(halted), 0);
    step();
    chk("R2", "B END halts", int'(halted), 1);
    cc0 = ~cc0;
    cc1 = ~cc1;
    step();
    step();
    chk("R2", "B halted holds addr", int'(fetchAddr), 42);
    chk("R2", "B halted holds loopCtr", int'(loopCtr), 2);

    // Program C: self-call fills the stack, next push overflows (R9)
    clearProg();
    putI(60, 4'd4, 60, 5, 0, 0, 0, 0, 0, 0, 2'd0);
    putI(61, 4'd1, 0, 0, 0, 0, 0, 0, 0, 0, 2'd0);
    doReset(60);
    for (int k = 0; k < 8; k++) step();
    chk("R9", "C full stack addr", int'(fetchAddr), 60);
    chk("R9", "C no overflow yet", int'(overflowErr), 0);
    step();
    chk("R9", "C overflow flag", int'(overflowErr), 1);
    chk("R9", "C push dropped addr", int'(fetchAddr), 61);
    step();
    chk("R9", "C flag sticky", int'(overflowErr), 1);
    chk("R2", "C halted", int'(halted), 1);

    // Reset clears flags; Program D: nested calls unwind LIFO (R1, R8)
    clearProg();
    putI(80, 4'd4, 90, 3, 0, 0, 0, 0, 0, 0, 2'd0);
    putI(81, 4'd1, 0, 0, 0, 0, 0, 0, 0, 0, 2'd0);
    putI(90, 4'd4, 95, 1, 0, 0, 0, 0, 0, 0, 2'd0);
    putI(91, 4'd15, 0, 0, 0, 0, 0, 0, 0, 0, 2'd0);
    putI(93, 4'd1, 0, 0, 0, 0, 0, 0, 0, 0, 2'd0);
    putI(96, 4'd1, 0, 0, 0, 0, 0, 0, 0, 0, 2'd0);
    doReset(80);
    chk("R1", "re-reset fetchAddr", int'(fetchAddr), 80);
    chk("R1", "re-reset overflowErr", int'(overflowErr), 0);
    chk("R1", "re-reset halted", int'(halted), 0);
    step();
    step();
    chk("R8", "D inner call addr", int'(fetchAddr), 95);
    step();
    step();
    chk("R8", "D inner return addr", int'(fetchAddr), 91);
    step();
    chk("R2", "D unlisted opcode advances", int'(fetchAddr), 92);
    step();
    step();
    chk("R8", "D outer return addr", int'(fetchAddr), 81);
    chk("R5", "D END at end address skipped", int'(halted), 0);
    step();
    chk("R2", "D final halt", int'(halted), 1);

    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule